// File: doc/BRIEF.md
# LED Brightness Ramp Sequencer

This block plays a brightness pattern for one PWM channel. It walks an index through a window of a small brightness table, one entry per step interval, and presents the table value at that index as the channel's duty value. A step interval is a programmable number of millisecond tick strobes. The walk can run upward or downward and can stop after one pass or loop. In ping-pong mode it bounces between the two ends of the window. Each end can also hold its entry for a programmable number of extra steps.

The block has one bit in a shared start word that holds one bit per channel. Writing the bit starts or restarts this channel's sequence. Several sequencers can be started in the same cycle by setting several bits. The configuration (window bounds, step length, pause counts and mode flags) is captured when a start is accepted. The table is a register array with a simple write port. It stands in for a shared lookup store and is read combinationally at the current index.

Top module: `led_ramp_sequencer`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `lut_addr` is 0.
- R2: A start is accepted only when bit `CH_SEL` of `start_mask` is 1. Other bits of `start_mask` have no effect.
- R3: While running, the index changes only on a step. A step occurs on every `cfg_step`-th tick strobe counted from the start. A `cfg_step` of 0 behaves as 1.
- R4: With `cfg_flags` bit 4 = 1 (upward), a start places the index at `cfg_lo_idx`, and each step raises it by one until it reaches `cfg_hi_idx`.
- R5: With `cfg_flags` bit 4 = 0 (downward), a start places the index at `cfg_hi_idx`, and each step lowers it by one until it reaches `cfg_lo_idx`.
- R6: When `cfg_lo_idx` equals `cfg_hi_idx`, the window is the whole table, from 0 to `LUT_DEPTH-1`.
- R7: With bit 3 = 1 (loop) and bit 2 = 0, the first step after the far end is reached returns the index to the starting index.
- R8: With bit 2 = 1 (ping-pong), the first step after an end is reached reverses the direction and moves the index one place back into the window.
- R9: Bit 1 enables the upper-end pause of `cfg_hi_pause` steps. Bit 0 enables the lower-end pause of `cfg_lo_pause` steps. An active pause of N keeps the end entry for N+1 steps in total. A pause with a count of 0, or with its bit cleared, adds nothing. Only the pause of the end actually reached is applied.
- R10: With bit 3 = 0 (single pass), the sequence ends at the last end it reaches, after that end's pause. Without ping-pong that is one leg; with ping-pong it is out and back. When it ends, `busy` falls, `done` rises, and the index holds until the next start.
- R11: A start while running or pausing restarts from the first index, with fresh step and pause counts.
- R12: Configuration inputs that change after a start have no effect until the next start.
- R13: `duty` equals the table entry at `lut_addr` in the same cycle. Table entries are written through `lut_we`/`lut_waddr`/`lut_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle millisecond tick strobe |
| start_mask | input | NCH | Shared start word, one bit per channel |
| cfg_lo_idx | input | IDX_W | Lower window bound |
| cfg_hi_idx | input | IDX_W | Upper window bound |
| cfg_step | input | 9 | Ticks per step |
| cfg_hi_pause | input | PAUSE_W | Upper-end pause, in steps |
| cfg_lo_pause | input | PAUSE_W | Lower-end pause, in steps |
| cfg_flags | input | 5 | Mode: [4] upward, [3] loop, [2] ping-pong, [1] upper pause on, [0] lower pause on |
| lut_we | input | 1 | Table write enable |
| lut_waddr | input | IDX_W | Table write address |
| lut_wdata | input | DUTY_W | Table write data |
| lut_addr | output | IDX_W | Current table index |
| duty | output | DUTY_W | Duty value, the table entry at `lut_addr` |
| busy | output | 1 | Sequence running or pausing |
| done | output | 1 | Single pass finished |

## Verification
A start or a completing tick is registered at one rising edge. Its result on `lut_addr`, `busy` and `done` is therefore due right after that edge, and `duty` follows in the same cycle through the combinational table read. The bench drives each strobe for exactly one cycle, starting at a falling edge, and samples at the next falling edge. Each sample falls after exactly the edge that registered the strobe, so the number of ticks in a test is the number of steps the expected sequence advances. For step lengths above one, it checks the index on each intermediate tick to confirm that nothing moves before the counted tick. Pause tests list each held step on its own tick.

// File: rtl/led_ramp_pkg.sv
package led_ramp_pkg;

  localparam int STEP_W = 9;
  localparam int FLAG_W = 5;

  // packed order puts 'up' at bit 4 and 'lo_pz' at bit 0
  typedef struct packed {
    logic up;
    logic rep;
    logic tog;
    logic hi_pz;
    logic lo_pz;
  } ramp_flags_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PLAY  = 2'd1,
    PH_PAUSE = 2'd2,
    PH_HOLD  = 2'd3
  } ramp_phase_t;

  // a step is due when the tick count reaches the length; 0 counts as 1
  function automatic logic step_due(input int unsigned cnt, input int unsigned len);
    int unsigned eff;
    eff = (len == 0) ? 1 : len;
    return (cnt + 1) >= eff;
  endfunction

  function automatic int unsigned eff_len(input int unsigned len);
    return (len == 0) ? 1 : len;
  endfunction

endpackage

// File: rtl/ramp_lut_bank.sv
module ramp_lut_bank #(
  parameter int DEPTH  = 64,
  parameter int DUTY_W = 9,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DUTY_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DUTY_W-1:0] rdata
);

  logic [DUTY_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (we && (waddr == IDX_W'(g))) begin
        mem[g] <= wdata;
      end
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ramp_step_timer.sv
module ramp_step_timer
  import led_ramp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic              tick,
  input  logic [STEP_W-1:0] cfg_step,
  output logic              step_evt
);

  logic [STEP_W-1:0] tcnt;
  logic [STEP_W-1:0] step_r;
  logic              due;

  always_comb begin
    due      = step_due(32'(tcnt), 32'(step_r));
    step_evt = run && tick && !start && due;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt   <= '0;
      step_r <= '0;
    end else if (start) begin
      tcnt   <= '0;
      step_r <= cfg_step;
    end else if (run && tick) begin
      tcnt <= due ? '0 : tcnt + 1'b1;
    end
  end

  // R3: the tick count never reaches the captured step length
  a_r3_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (32'(tcnt) < eff_len(32'(step_r))));

endmodule

// File: rtl/ramp_walker.sv
module ramp_walker
  import led_ramp_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int PAUSE_W = 8,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               step_evt,
  input  logic [IDX_W-1:0]   cfg_lo,
  input  logic [IDX_W-1:0]   cfg_hi,
  input  logic [PAUSE_W-1:0] cfg_hp,
  input  logic [PAUSE_W-1:0] cfg_lp,
  input  ramp_flags_t        cfg_flags,
  output logic [IDX_W-1:0]   idx_o,
  output logic               busy_o,
  output logic               done_o
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DEPTH - 1);

  ramp_phase_t        phase;
  logic [IDX_W-1:0]   idx, lo_r, hi_r;
  logic [PAUSE_W-1:0] hp_r, lp_r, rem;
  ramp_flags_t        flg_r;
  logic               dir_up, first_up;

  // named internal events
  logic               full_win;
  logic [IDX_W-1:0]   lo_eff, hi_eff;
  logic               at_end;
  logic [PAUSE_W-1:0] pause_len;
  logic               turn_now;
  logic               finish;
  logic [IDX_W-1:0]   turn_idx;
  logic               turn_dir;

  function automatic logic [IDX_W-1:0] nudge(input logic [IDX_W-1:0] i, input logic up);
    return up ? i + 1'b1 : i - 1'b1;
  endfunction

  always_comb begin
    full_win  = (cfg_lo == cfg_hi);
    lo_eff    = full_win ? '0 : cfg_lo;
    hi_eff    = full_win ? TOP_IDX : cfg_hi;
    at_end    = dir_up ? (idx == hi_r) : (idx == lo_r);
    pause_len = dir_up ? (flg_r.hi_pz ? hp_r : '0) : (flg_r.lo_pz ? lp_r : '0);
    turn_now  = step_evt &&
                (((phase == PH_PLAY) && at_end && (pause_len == '0)) ||
                 ((phase == PH_PAUSE) && (rem == PAUSE_W'(1))));
    finish    = !flg_r.rep && (!flg_r.tog || (dir_up != first_up));
    turn_dir  = flg_r.tog ? !dir_up : dir_up;
    turn_idx  = flg_r.tog ? nudge(idx, !dir_up) : (first_up ? lo_r : hi_r);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      idx      <= '0;
      lo_r     <= '0;
      hi_r     <= '0;
      hp_r     <= '0;
      lp_r     <= '0;
      rem      <= '0;
      flg_r    <= '0;
      dir_up   <= 1'b1;
      first_up <= 1'b1;
    end else if (start) begin
      phase    <= PH_PLAY;
      lo_r     <= lo_eff;
      hi_r     <= hi_eff;
      hp_r     <= cfg_hp;
      lp_r     <= cfg_lp;
      flg_r    <= cfg_flags;
      rem      <= '0;
      dir_up   <= cfg_flags.up;
      first_up <= cfg_flags.up;
      idx      <= cfg_flags.up ? lo_eff : hi_eff;
    end else if (turn_now) begin
      rem <= '0;
      if (finish) begin
        phase <= PH_HOLD;
      end else begin
        phase  <= PH_PLAY;
        idx    <= turn_idx;
        dir_up <= turn_dir;
      end
    end else if (step_evt && (phase == PH_PLAY)) begin
      if (!at_end) begin
        idx <= nudge(idx, dir_up);
      end else begin
        phase <= PH_PAUSE;
        rem   <= pause_len;
      end
    end else if (step_evt && (phase == PH_PAUSE)) begin
      rem <= rem - 1'b1;
    end
  end

  assign idx_o  = idx;
  assign busy_o = (phase == PH_PLAY) || (phase == PH_PAUSE);
  assign done_o = (phase == PH_HOLD);

  // R4 R5: a running index stays inside the captured window
  a_r4_idx_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ((idx >= lo_r) && (idx <= hi_r)));

  // R3: without a step or a start the index does not move
  a_r3_idx_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step_evt) |=> $stable(idx));

  // R9: a pause never sits at a zero count
  a_r9_pause_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAUSE) |-> (rem != '0));

  // R10: a finished pass holds its index until a new start
  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start) |=> (done_o && $stable(idx)));

  // R1 R10: running and finished are exclusive
  a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  // R4 R5: a mid-window step moves the index by exactly one
  a_r4_single_move: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !start && (phase == PH_PLAY) && !at_end) |=>
      ((idx == $past(idx) + 1'b1) || (idx == $past(idx) - 1'b1)));

endmodule

// File: rtl/led_ramp_sequencer.sv
module led_ramp_sequencer
  import led_ramp_pkg::*;
#(
  parameter int LUT_DEPTH = 64,
  parameter int DUTY_W    = 9,
  parameter int PAUSE_W   = 8,
  parameter int NCH       = 4,
  parameter int CH_SEL    = 0,
  localparam int IDX_W    = $clog2(LUT_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_ms,
  input  logic [NCH-1:0]     start_mask,
  input  logic [IDX_W-1:0]   cfg_lo_idx,
  input  logic [IDX_W-1:0]   cfg_hi_idx,
  input  logic [8:0]         cfg_step,
  input  logic [PAUSE_W-1:0] cfg_hi_pause,
  input  logic [PAUSE_W-1:0] cfg_lo_pause,
  input  logic [4:0]         cfg_flags,
  input  logic               lut_we,
  input  logic [IDX_W-1:0]   lut_waddr,
  input  logic [DUTY_W-1:0]  lut_wdata,
  output logic [IDX_W-1:0]   lut_addr,
  output logic [DUTY_W-1:0]  duty,
  output logic               busy,
  output logic               done
);

  logic        start_hit;
  logic        step_evt;
  ramp_flags_t flags_in;

  assign start_hit = start_mask[CH_SEL];
  assign flags_in  = ramp_flags_t'(cfg_flags);

  ramp_step_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_hit),
    .run      (busy),
    .tick     (tick_ms),
    .cfg_step (STEP_W'(cfg_step)),
    .step_evt (step_evt)
  );

  ramp_walker #(
    .DEPTH   (LUT_DEPTH),
    .PAUSE_W (PAUSE_W)
  ) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_hit),
    .step_evt  (step_evt),
    .cfg_lo    (cfg_lo_idx),
    .cfg_hi    (cfg_hi_idx),
    .cfg_hp    (cfg_hi_pause),
    .cfg_lp    (cfg_lo_pause),
    .cfg_flags (flags_in),
    .idx_o     (lut_addr),
    .busy_o    (busy),
    .done_o    (done)
  );

  ramp_lut_bank #(
    .DEPTH  (LUT_DEPTH),
    .DUTY_W (DUTY_W)
  ) u_lut (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (lut_we),
    .waddr (lut_waddr),
    .wdata (lut_wdata),
    .raddr (lut_addr),
    .rdata (duty)
  );

  // R2: a start is followed by a running sequence at the next edge
  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> (busy && !done));

endmodule

// File: tb/led_ramp_sequencer_test.sv
module led_ramp_sequencer_test;

  localparam int DEPTH = 64;
  localparam int IW    = 6;
  localparam int DW    = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_ms = 1'b0;
  logic [3:0]    start_mask = '0;
  logic [IW-1:0] cfg_lo_idx = '0, cfg_hi_idx = '0;
  logic [8:0]    cfg_step = 9'd1;
  logic [7:0]    cfg_hi_pause = '0, cfg_lo_pause = '0;
  logic [4:0]    cfg_flags = '0;
  logic          lut_we = 1'b0;
  logic [IW-1:0] lut_waddr = '0;
  logic [DW-1:0] lut_wdata = '0;
  logic [IW-1:0] lut_addr;
  logic [DW-1:0] duty;
  logic          busy, done;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  led_ramp_sequencer uut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .start_mask(start_mask),
    .cfg_lo_idx(cfg_lo_idx), .cfg_hi_idx(cfg_hi_idx), .cfg_step(cfg_step),
    .cfg_hi_pause(cfg_hi_pause), .cfg_lo_pause(cfg_lo_pause), .cfg_flags(cfg_flags),
    .lut_we(lut_we), .lut_waddr(lut_waddr), .lut_wdata(lut_wdata),
    .lut_addr(lut_addr), .duty(duty), .busy(busy), .done(done)
  );

  function automatic int lutv(input int i);
    return (i * 37 + 5) % 512;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_at(input string req, input int exp);
    chk(req, int'(lut_addr), exp);
    chk({req, " R13 duty"}, int'(duty), lutv(exp));
  endtask

  task automatic do_tick();
    @(negedge clk) tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
  endtask

  task automatic tk(input string req, input int exp);
    do_tick();
    chk_at(req, exp);
  endtask

  task automatic kick(input logic [3:0] m);
    @(negedge clk) start_mask = m;
    @(negedge clk) start_mask = '0;
  endtask

  task automatic set_cfg(input int lo, input int hi, input int st,
                         input int hp, input int lp, input logic [4:0] fl);
    @(negedge clk);
    cfg_lo_idx = IW'(lo); cfg_hi_idx = IW'(hi); cfg_step = 9'(st);
    cfg_hi_pause = 8'(hp); cfg_lo_pause = 8'(lp); cfg_flags = fl;
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 addr", int'(lut_addr), 0);
  endtask

  task automatic t_load_lut();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      lut_we = 1'b1; lut_waddr = IW'(i); lut_wdata = DW'(lutv(i));
    end
    @(negedge clk) lut_we = 1'b0;
  endtask

  task automatic t_mask_other();
    set_cfg(2, 5, 1, 0, 0, 5'b10000);
    kick(4'b0010);
    chk("R2 other bit no start busy", int'(busy), 0);
    chk("R2 other bit no start done", int'(done), 0);
  endtask

  task automatic t_fwd_single();
    set_cfg(2, 5, 1, 0, 0, 5'b10000);
    kick(4'b0001);
    chk_at("R4 start at lo", 2);
    chk("R2 busy after start", int'(busy), 1);
    tk("R4 fwd", 3); tk("R4 fwd", 4); tk("R4 fwd", 5);
    do_tick();
    chk("R10 done", int'(done), 1);
    chk("R10 not busy", int'(busy), 0);
    chk_at("R10 held", 5);
    tk("R10 held after tick", 5);
    kick(4'b1110);
    chk("R2 other bits ignored when done", int'(done), 1);
  endtask

  task automatic t_step_len();
    set_cfg(8, 12, 3, 0, 0, 5'b10000);
    kick(4'b0001);
    tk("R3 hold tick1", 8); tk("R3 hold tick2", 8); tk("R3 move tick3", 9);
    tk("R3 hold", 9); tk("R3 hold", 9); tk("R3 move", 10);
    set_cfg(8, 12, 0, 0, 0, 5'b10000);
    kick(4'b0001);
    tk("R3 zero step", 9); tk("R3 zero step", 10);
  endtask

  task automatic t_reverse_loop();
    set_cfg(10, 12, 1, 0, 0, 5'b01000);
    kick(4'b0001);
    chk_at("R5 start at hi", 12);
    tk("R5 down", 11); tk("R5 down", 10);
    tk("R7 wrap to hi", 12);
    tk("R5 down again", 11);
  endtask

  task automatic t_fwd_loop();
    set_cfg(4, 6, 1, 0, 0, 5'b11000);
    kick(4'b0001);
    tk("R4 up", 5); tk("R4 up", 6);
    tk("R7 wrap to lo", 4);
    chk("R7 still busy", int'(busy), 1);
  endtask

  task automatic t_full_table();
    set_cfg(7, 7, 1, 0, 0, 5'b10000);
    kick(4'b0001);
    chk_at("R6 full starts at 0", 0);
    for (int i = 1; i < DEPTH; i++) begin
      do_tick();
      if (i == 7 || i == 8 || i == DEPTH - 1) chk_at("R6 full walk", i);
    end
    do_tick();
    chk("R6 full ends done", int'(done), 1);
    chk_at("R6 ends at top", DEPTH - 1);
  endtask

  task automatic t_pingpong();
    set_cfg(1, 3, 1, 2, 1, 5'b11100);
    kick(4'b0001);
    tk("R8 pp", 2); tk("R8 pp", 3); tk("R9 pause bit off", 2);
    tk("R8 pp", 1); tk("R8 turn at lo", 2);
  endtask

  task automatic t_pauses();
    set_cfg(1, 3, 1, 2, 1, 5'b11111);
    kick(4'b0001);
    tk("R9 pz", 2); tk("R9 pz", 3);
    tk("R9 hi pause 1", 3); tk("R9 hi pause 2", 3);
    tk("R9 after hi pause", 2); tk("R9 pz", 1);
    tk("R9 lo pause", 1); tk("R9 after lo pause", 2);
    set_cfg(1, 3, 1, 0, 4, 5'b11111);
    kick(4'b0001);
    tk("R9 zero count", 2); tk("R9 zero count", 3); tk("R9 zero hi no pause", 2);
  endtask

  task automatic t_pp_single();
    set_cfg(1, 3, 1, 0, 0, 5'b10100);
    kick(4'b0001);
    tk("R10 pp", 2); tk("R10 pp", 3); tk("R10 pp back", 2); tk("R10 pp back", 1);
    chk("R10 pp still busy at far side", int'(busy), 1);
    do_tick();
    chk("R10 pp done", int'(done), 1);
    chk_at("R10 pp rests at lo", 1);
  endtask

  task automatic t_restart();
    set_cfg(2, 3, 1, 3, 0, 5'b11010);
    kick(4'b0001);
    tk("R11 pre", 3); tk("R11 into pause", 3);
    kick(4'b0001);
    chk_at("R11 restart at first", 2);
    tk("R11 after restart", 3);
    tk("R11 fresh pause", 3); tk("R11 fresh pause", 3); tk("R11 fresh pause", 3);
    tk("R11 wrap after full pause", 2);
    set_cfg(2, 6, 1, 0, 0, 5'b11000);
    kick(4'b0001);
    tk("R11 run", 3); tk("R11 run", 4);
    kick(4'b0100);
    chk_at("R2 other bit no restart", 4);
    kick(4'b0001);
    chk_at("R11 restart mid run", 2);
  endtask

  task automatic t_snapshot();
    set_cfg(2, 4, 1, 0, 0, 5'b10000);
    kick(4'b0001);
    set_cfg(9, 20, 5, 3, 3, 5'b01111);
    tk("R12 old step len", 3); tk("R12 old window", 4);
    do_tick();
    chk("R12 old single pass", int'(done), 1);
    chk_at("R12 held", 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_lut();
    t_mask_other();
    t_fwd_single();
    t_step_len();
    t_reverse_loop();
    t_fwd_loop();
    t_full_table();
    t_pingpong();
    t_pauses();
    t_pp_single();
    t_restart();
    t_snapshot();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule